// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio of 128·N + A and marks the end of every division cycle with a single pulse. That pulse is meant for the comparison input of a phase detector in a frequency synthesizer. The scheme uses a behavioural dual-modulus prescaler that divides by 128 or by 129. A 7-bit swallow counter keeps the prescaler at 129 for the first A prescaler periods of a cycle. It then releases the prescaler to 128 for the remaining N − A periods, which are counted by an 11-bit main counter. With a reference divider R and a reference oscillator fOSC, the loop settles at an output frequency of (128·N + A) · fOSC / R.

The ratio inputs N and A come from an upstream holding register. The block reads them only at a cycle boundary: once on the first clock after reset, and then on every clock edge where the pulse is issued. A cycle therefore never runs with a mix of old and new settings. If A is programmed at or above N, the block uses N − 1 in its place and reports the correction on a status output for that cycle.

Top module: `swallow_divider`

## Requirements
- R1: While rst_n is low, cmp_pulse_o, mod_hi_o and clamp_o are all 0.
- R2: In steady state with A < N, successive rising edges of cmp_pulse_o lie exactly 128·N + A input clocks apart.
- R3: cmp_pulse_o is high for exactly one input clock per division cycle.
- R4: The first clock edge with rst_n high loads N and A. cmp_pulse_o then rises 128·N + A edges later, which is the (128·N + A + 1)-th clock period after rst_n was released.
- R5: mod_hi_o (1 = divide by 129, 0 = divide by 128) is high for the first 129·A clocks of a cycle, counted from the clock in which cmp_pulse_o is high. It stays low for the rest of the cycle.
- R6: With A = 0, mod_hi_o stays low for the whole cycle and the period is 128·N.
- R7: N and A are sampled only at a cycle boundary. Changing them inside a running cycle does not alter that cycle's length or modulus pattern; the new values govern the following cycle.
- R8: If A ≥ N is loaded, the cycle behaves as if A = N − 1. clamp_o is 1 from that cycle's boundary until the next one. clamp_o returns to 0 at the next boundary that loads a legal pair.
- R9: The legal corner N = 16 with A = N − 1 runs at 128·N + A with clamp_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_ratio_i | input | 11 | Main counter ratio N (legal 16..2047) |
| a_ratio_i | input | 7 | Swallow count A (legal 0..127, below N) |
| cmp_pulse_o | output | 1 | One-clock pulse at the end of each division cycle |
| mod_hi_o | output | 1 | Prescaler modulus control, 1 selects 129 |
| clamp_o | output | 1 | Current cycle runs with A replaced by N − 1 |

## Verification
The bench measures every cycle's length and counts its divide-by-129 clocks. A prescaler off by one count, or a swallow counter that stops one period early or late, shows up directly as a period or modulus-count mismatch. It runs A = 0, A = N − 1 and several illegal pairs with A ≥ N. A design without the clamp would swallow more periods than the main counter allows and produce a wrong period and a stuck modulus. It also changes N and A inside a running cycle and expects no effect until the next boundary; a design that reloads early would give a partial-ratio cycle. The first-pulse latency after reset is checked separately, because an extra load stage would shift it.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
    // log2 of the base prescaler modulus (128)
    localparam int PRESC_LOG2 = 7;
    // width of the main (N) counter
    localparam int MAIN_W     = 11;
    // width of the swallow (A) counter
    localparam int SWAL_W     = 7;
endpackage

// File: rtl/swallow_presc.sv
module swallow_presc #(
    parameter  int PRESC_LOG2 = swallow_div_pkg::PRESC_LOG2,
    localparam int CW         = PRESC_LOG2 + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          mod_hi,
    output logic          tick,
    output logic [CW-1:0] cnt_o
);
    // terminal counts for the two moduli: 2^k + 1 and 2^k input clocks
    localparam logic [CW-1:0] LAST_HI = CW'(2 ** PRESC_LOG2);
    localparam logic [CW-1:0] LAST_LO = CW'(2 ** PRESC_LOG2 - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } presc_st_t;

    presc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = en && (st_q.cnt == (mod_hi ? LAST_HI : LAST_LO));
        if (!en || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/swallow_guard.sv
module swallow_guard #(
    parameter int MAIN_W = swallow_div_pkg::MAIN_W,
    parameter int SWAL_W = swallow_div_pkg::SWAL_W
) (
    input  logic [MAIN_W-1:0] n_i,
    input  logic [SWAL_W-1:0] a_i,
    output logic [SWAL_W-1:0] a_eff_o,
    output logic              clamp_o
);
    logic [MAIN_W-1:0] a_wide;
    logic [MAIN_W-1:0] n_less;

    always_comb begin
        a_wide  = MAIN_W'(a_i);
        n_less  = n_i - MAIN_W'(1);
        clamp_o = (a_wide >= n_i);
        // when clamped, N - 1 < A <= 2^SWAL_W - 1, so it fits the swallow width
        a_eff_o = clamp_o ? SWAL_W'(n_less) : a_i;
    end
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl #(
    parameter int MAIN_W = swallow_div_pkg::MAIN_W,
    parameter int SWAL_W = swallow_div_pkg::SWAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [MAIN_W-1:0] n_i,
    input  logic [SWAL_W-1:0] a_i,
    input  logic              clamp_i,
    output logic              run_o,
    output logic              pulse_o,
    output logic              mod_hi_o,
    output logic              clamp_o,
    output logic [MAIN_W-1:0] n_cnt_o,
    output logic [SWAL_W-1:0] a_cnt_o
);
    typedef struct packed {
        logic              run;
        logic              pulse;
        logic              clamp;
        logic [MAIN_W-1:0] n;
        logic [SWAL_W-1:0] a;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!st_q.run) begin
            // first edge out of reset: initial load, no pulse
            st_d.run   = 1'b1;
            st_d.n     = n_i;
            st_d.a     = a_i;
            st_d.clamp = clamp_i;
        end else if (tick) begin
            if (st_q.n <= MAIN_W'(1)) begin
                // last prescaler period of the cycle: boundary
                st_d.pulse = 1'b1;
                st_d.n     = n_i;
                st_d.a     = a_i;
                st_d.clamp = clamp_i;
            end else begin
                st_d.n = st_q.n - MAIN_W'(1);
                if (st_q.a != '0) begin
                    st_d.a = st_q.a - SWAL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o    = st_q.run;
    assign pulse_o  = st_q.pulse;
    assign mod_hi_o = (st_q.a != '0);
    assign clamp_o  = st_q.clamp;
    assign n_cnt_o  = st_q.n;
    assign a_cnt_o  = st_q.a;
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
    parameter  int PRESC_LOG2 = swallow_div_pkg::PRESC_LOG2,
    parameter  int MAIN_W     = swallow_div_pkg::MAIN_W,
    parameter  int SWAL_W     = swallow_div_pkg::SWAL_W,
    localparam int CW         = PRESC_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] n_ratio_i,
    input  logic [SWAL_W-1:0] a_ratio_i,
    output logic              cmp_pulse_o,
    output logic              mod_hi_o,
    output logic              clamp_o
);
    logic [SWAL_W-1:0] a_eff;
    logic              clamp_next;
    logic              run;
    logic              presc_tick;
    logic [CW-1:0]     presc_cnt;
    logic [MAIN_W-1:0] n_cnt;
    logic [SWAL_W-1:0] a_cnt;

    swallow_guard #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_guard (
        .n_i     (n_ratio_i),
        .a_i     (a_ratio_i),
        .a_eff_o (a_eff),
        .clamp_o (clamp_next)
    );

    swallow_ctrl #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (presc_tick),
        .n_i      (n_ratio_i),
        .a_i      (a_eff),
        .clamp_i  (clamp_next),
        .run_o    (run),
        .pulse_o  (cmp_pulse_o),
        .mod_hi_o (mod_hi_o),
        .clamp_o  (clamp_o),
        .n_cnt_o  (n_cnt),
        .a_cnt_o  (a_cnt)
    );

    swallow_presc #(.PRESC_LOG2(PRESC_LOG2)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (run),
        .mod_hi (mod_hi_o),
        .tick   (presc_tick),
        .cnt_o  (presc_cnt)
    );
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
    parameter  int PRESC_LOG2 = swallow_div_pkg::PRESC_LOG2,
    parameter  int MAIN_W     = swallow_div_pkg::MAIN_W,
    parameter  int SWAL_W     = swallow_div_pkg::SWAL_W,
    localparam int CW         = PRESC_LOG2 + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pulse,
    input logic              mod_hi,
    input logic              tick,
    input logic              run,
    input logic [CW-1:0]     presc_cnt,
    input logic [MAIN_W-1:0] n_cnt,
    input logic [SWAL_W-1:0] a_cnt
);
    // R3: one clock wide
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R2: a boundary pulse follows only a completed prescaler period
    assert_pulse_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(tick));

    // R2: prescaler count never passes the long-modulus terminal value
    assert_presc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        presc_cnt <= CW'(2 ** PRESC_LOG2));

    // R5: modulus returns to 128 only at the end of a prescaler period
    assert_mod_drop_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_hi) |-> $past(tick));

    // R8: the swallow count in use always stays below the main count
    assert_swallow_below_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (MAIN_W'(a_cnt) < n_cnt));

    // R7: counters move only on prescaler periods, never from the ratio inputs
    assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> ($stable(n_cnt) && $stable(a_cnt)));
endmodule

bind swallow_divider swallow_divider_chk #(
    .PRESC_LOG2 (PRESC_LOG2),
    .MAIN_W     (MAIN_W),
    .SWAL_W     (SWAL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse     (cmp_pulse_o),
    .mod_hi    (mod_hi_o),
    .tick      (presc_tick),
    .run       (run),
    .presc_cnt (presc_cnt),
    .n_cnt     (n_cnt),
    .a_cnt     (a_cnt)
);

// File: tb/swallow_divider_test.sv
module swallow_divider_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] n_in = 11'd16;
    logic [6:0]  a_in = 7'd0;
    logic        pulse, mod_hi, clamp;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int    period;
        int    hi;
        bit    clamp;
        string tag;
    } exp_t;

    exp_t expq[$];

    always #(CLK_P/2) clk = ~clk;

    swallow_divider uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .n_ratio_i   (n_in),
        .a_ratio_i   (a_in),
        .cmp_pulse_o (pulse),
        .mod_hi_o    (mod_hi),
        .clamp_o     (clamp)
    );

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic exp_t model(int n, int a, string tag);
        exp_t e;
        int   ae;
        ae       = (a >= n) ? n - 1 : a;
        e.period = 128 * n + ae;
        e.hi     = 129 * ae;
        e.clamp  = (a >= n);
        e.tag    = tag;
        return e;
    endfunction

    task automatic wait_pulse();
        do @(negedge clk); while (pulse !== 1'b1);
    endtask

    task automatic drive(int n, int a, string tag);
        n_in = 11'(n);
        a_in = 7'(a);
        expq.push_back(model(n, a, tag));
    endtask

    // monitor: measures every complete cycle and compares with the queue
    initial begin
        int cnt = 0;
        int hi = 0;
        bit seen = 0;
        bit clamp_start = 0;
        bit just_pulsed = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (just_pulsed) begin
                check(pulse === 1'b0, "R3", "pulse width", int'(pulse), 0);
                just_pulsed = 0;
            end
            if (pulse === 1'b1) begin
                if (seen) begin
                    if (expq.size() == 0) begin
                        check(1'b0, "R2", "unexpected cycle", cnt, 0);
                    end else begin
                        e = expq.pop_front();
                        check(cnt == e.period, e.tag, "period", cnt, e.period);
                        check(hi == e.hi, "R5", "mod129 clocks", hi, e.hi);
                        check(clamp_start == e.clamp, "R8", "clamp flag",
                              int'(clamp_start), int'(e.clamp));
                    end
                end
                seen        = 1;
                just_pulsed = 1;
                cnt         = 1;
                hi          = (mod_hi === 1'b1) ? 1 : 0;
                clamp_start = (clamp === 1'b1);
            end else begin
                cnt++;
                if (mod_hi === 1'b1) hi++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // driver
    initial begin
        int lat;
        repeat (5) @(negedge clk);
        check(pulse === 1'b0, "R1", "pulse in reset", int'(pulse), 0);
        check(mod_hi === 1'b0, "R1", "mod_hi in reset", int'(mod_hi), 0);
        check(clamp === 1'b0, "R1", "clamp in reset", int'(clamp), 0);
        rst_n = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (pulse !== 1'b1);
        check(lat == 2049, "R4", "first pulse latency", lat, 2049);

        // cycle started at the first pulse runs with (16,0): A = 0 case
        expq.push_back(model(16, 0, "R6"));
        drive(16, 5, "R2");
        wait_pulse(); drive(16, 15, "R9");
        wait_pulse(); drive(20, 19, "R2");
        wait_pulse(); drive(17, 30, "R8");
        wait_pulse(); drive(40, 100, "R8");
        wait_pulse(); drive(16, 127, "R8");
        wait_pulse(); drive(33, 1, "R5");
        // mid-cycle changes: junk, then final values, all inside a running cycle
        wait_pulse();
        n_in = 11'd16;
        a_in = 7'd16;
        repeat (500) @(negedge clk);
        drive(18, 7, "R7");
        wait_pulse(); drive(100, 99, "R2");
        wait_pulse(); drive(16, 0, "R8");
        wait_pulse();
        wait_pulse();
        repeat (2) @(negedge clk);
        check(expq.size() == 0, "R2", "cycles left unmeasured", expq.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule